// File: doc/BRIEF.md
# Fractional-Increment Nanosecond Time Counter

This block keeps a free-running time-of-day value for packet timestamping. The value is a 64-bit count of whole nanoseconds. A 32-bit fraction of a nanosecond sits below it and is never seen at the ports. On every clock tick, while the run bit is set, the block adds a step to the combined 96-bit value. The step is a programmable increment (8 integer bits, 32 fraction bits) multiplied by a factor that the link-rate input selects. Carries out of the fraction flow into the nanosecond count. The full 64-bit time is also driven on a port for the datapath that stamps frames.

Software uses a small 32-bit register interface to start and stop the counter, set the time and set the increment. Each 64-bit quantity is split into a low word and a high word. Reading the low time word takes a snapshot of the whole value, so a later read of the high word returns the matching half. Writing a low word only stages it, and the write of the high word commits both halves in one edge. Software trims the frequency by committing a new increment. The reset increment is 0x01_99999999, which is 1.6 ns per tick.

Top module: `tod_timebase`

## Requirements
- R1: After reset `time_ns` is 0, the control register reads 0, and the increment reads 0x99999999 at the low word and 0x00000001 at the high word.
- R2: The register addresses are 0 for control (bit 0 is run), 1 for the time low word, 2 for the time high word, 3 for the increment low word and 4 for the increment high word. A read request returns its data on `bus_rdata` with `bus_rvalid` high in the following cycle.
- R3: On each tick while run is 1, the 96-bit value {nanoseconds, 32-bit fraction} grows by the effective step. `time_ns` shows the nanosecond part, including carries out of the fraction.
- R4: The effective step is the increment multiplied by the link-rate factor: code 0 gives ×1, code 1 gives ×2 and code 2 gives ×20.
- R5: Link-rate code 3 gives a factor of 0, so `time_ns` holds its value.
- R6: While run is 0, `time_ns` holds its value.
- R7: A read of the time low word returns the low half and captures the high half. A later read of the time high word returns the captured half, even if the counter has since carried into its high half.
- R8: A write to the time low word only stages it and leaves `time_ns` unchanged. A write to the time high word loads {written word, staged low word} at that edge, and this happens whether run is 1 or 0.
- R9: A time load in a cycle where the counter would also advance takes priority: the loaded value appears exactly, the fraction is cleared, and counting resumes from a zero fraction.
- R10: A write to the increment low word only stages it and leaves the counting rate unchanged. A write to the increment high word commits {high word bits 7:0, staged low word}, and the new increment applies from the next tick.
- R11: The increment registers read back the active increment, never the staged low word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| link_rate | input | 2 | Rate code selecting the step factor (0:×1, 1:×2, 2:×20, 3:×0) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High in the cycle after a read request |
| time_ns | output | 64 | Current whole-nanosecond time |

## Verification
Two actions can fall in the same cycle: a time load and a normal tick advance. The bench provokes this by committing the time high word while run is set and the link rate is non-zero. It then judges the result in two ways. `time_ns` must equal the loaded value exactly in the next cycle. Every later sample must match the loaded value plus the floor of the elapsed ticks times the step, which holds only if the fraction restarted at zero. The low-word snapshot is checked against a counter that carries into its high half between the two reads.

// File: rtl/tod_pkg.sv
// Shared constants for the time counter: register addresses, link-rate
// codes and the rate-to-factor mapping. Assumes a 3-bit register address.
package tod_pkg;

    // Register addresses
    localparam int unsigned ADDR_CTRL    = 0;
    localparam int unsigned ADDR_TIME_LO = 1;
    localparam int unsigned ADDR_TIME_HI = 2;
    localparam int unsigned ADDR_INC_LO  = 3;
    localparam int unsigned ADDR_INC_HI  = 4;

    // Link-rate codes
    typedef enum logic [1:0] {
        LINK_FAST = 2'd0,
        LINK_MID  = 2'd1,
        LINK_GIG  = 2'd2,
        LINK_SLOW = 2'd3
    } link_rate_e;

    // Width of the step factor (largest factor is 20)
    localparam int unsigned FACTOR_W = 5;

    // Map a link-rate code to its step factor
    function automatic logic [FACTOR_W-1:0] rate_factor(input logic [1:0] code);
        case (code)
            LINK_FAST: return FACTOR_W'(1);
            LINK_MID:  return FACTOR_W'(2);
            LINK_GIG:  return FACTOR_W'(20);
            default:   return FACTOR_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/tod_step_gen.sv
// Step generator: multiplies the active increment by the factor that the
// link-rate code selects, using shift-and-add partial products.
// Assumes STEP_W is at least INC_W + FACTOR_W, so no product bit is lost.
module tod_step_gen
    import tod_pkg::*;
#(
    parameter int unsigned INC_W  = 40,
    parameter int unsigned STEP_W = INC_W + FACTOR_W
) (
    input  logic [INC_W-1:0]  inc_i,
    input  logic [1:0]        link_rate_i,
    output logic [STEP_W-1:0] step_o
);

    logic [FACTOR_W-1:0] factor;
    logic [STEP_W-1:0]   pp [FACTOR_W];

    // Decode the rate code into a factor
    assign factor = rate_factor(link_rate_i);

    // One shifted copy of the increment for each factor bit
    for (genvar b = 0; b < FACTOR_W; b++) begin : g_pp
        assign pp[b] = factor[b] ? (STEP_W'(inc_i) << b) : '0;
    end

    // Sum the partial products
    always_comb begin
        step_o = '0;
        for (int b = 0; b < FACTOR_W; b++) begin
            step_o = step_o + pp[b];
        end
    end

endmodule

// File: rtl/tod_accum.sv
// Time accumulator: holds {nanoseconds, fraction}. It loads a new
// nanosecond value (fraction cleared) or adds the step each tick while
// running. A load wins over an advance. Wrap of the 64-bit nanosecond
// field is assumed never to happen in service.
module tod_accum #(
    parameter int unsigned NS_W   = 64,
    parameter int unsigned FRAC_W = 32,
    parameter int unsigned STEP_W = 45
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              load_i,
    input  logic [NS_W-1:0]   load_val_i,
    input  logic [STEP_W-1:0] step_i,
    output logic [NS_W-1:0]   ns_o
);

    localparam int unsigned ACC_W = NS_W + FRAC_W;

    logic [ACC_W-1:0] acc_q;

    // Load has priority; otherwise advance by the step while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (load_i) begin
            acc_q <= {load_val_i, {FRAC_W{1'b0}}};
        end else if (run_i) begin
            acc_q <= acc_q + ACC_W'(step_i);
        end
    end

    assign ns_o = acc_q[ACC_W-1:FRAC_W];

    // R9
    load_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (ns_o == $past(load_val_i)) && (acc_q[FRAC_W-1:0] == '0));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !run_i) |=> $stable(acc_q));

    // R3
    no_backstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && run_i) |=> (acc_q >= $past(acc_q)));

    // R3
    step_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && run_i) |=> (acc_q - $past(acc_q)) == ACC_W'($past(step_i)));

endmodule

// File: rtl/tod_regif.sv
// Register interface: decodes 32-bit accesses, stages low words, commits
// time and increment on high-word writes, snapshots the time high half on
// low-word reads, and returns read data one cycle after the request.
// Assumes NS_W is twice DATA_W and INC_W lies between DATA_W and 2*DATA_W.
module tod_regif
    import tod_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 3,
    parameter int unsigned NS_W     = 64,
    parameter int unsigned INC_W    = 40,
    parameter logic [INC_W-1:0] BASE_INC = 40'h01_9999_9999
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic [NS_W-1:0]   time_i,
    output logic              run_o,
    output logic              load_o,
    output logic [NS_W-1:0]   load_val_o,
    output logic [INC_W-1:0]  inc_o
);

    localparam int unsigned NS_HI_W  = NS_W - DATA_W;
    localparam int unsigned INC_HI_W = INC_W - DATA_W;

    logic                sel_ctrl, sel_tlo, sel_thi, sel_ilo, sel_ihi;
    logic                run_q;
    logic [DATA_W-1:0]   time_lo_q;
    logic [DATA_W-1:0]   inc_lo_q;
    logic [INC_W-1:0]    inc_q;
    logic [NS_HI_W-1:0]  snap_hi_q;
    logic [DATA_W-1:0]   rdata_q;
    logic                rvalid_q;

    // Address decode
    assign sel_ctrl = (bus_addr == ADDR_W'(ADDR_CTRL));
    assign sel_tlo  = (bus_addr == ADDR_W'(ADDR_TIME_LO));
    assign sel_thi  = (bus_addr == ADDR_W'(ADDR_TIME_HI));
    assign sel_ilo  = (bus_addr == ADDR_W'(ADDR_INC_LO));
    assign sel_ihi  = (bus_addr == ADDR_W'(ADDR_INC_HI));

    // Run bit of the control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (bus_wr && sel_ctrl) begin
            run_q <= bus_wdata[0];
        end
    end

    // Staging register for the time low word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_lo_q <= '0;
        end else if (bus_wr && sel_tlo) begin
            time_lo_q <= bus_wdata;
        end
    end

    // Staging register for the increment low word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_lo_q <= '0;
        end else if (bus_wr && sel_ilo) begin
            inc_lo_q <= bus_wdata;
        end
    end

    // Active increment, committed in one edge by the high-word write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_q <= BASE_INC;
        end else if (bus_wr && sel_ihi) begin
            inc_q <= {bus_wdata[INC_HI_W-1:0], inc_lo_q};
        end
    end

    // Time load request with the full value, raised by the high-word write
    assign load_o     = bus_wr && sel_thi;
    assign load_val_o = {bus_wdata[NS_HI_W-1:0], time_lo_q};

    // Read path: registered data, and the high-half snapshot on low reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q   <= '0;
            rvalid_q  <= 1'b0;
            snap_hi_q <= '0;
        end else begin
            rvalid_q <= bus_rd;
            if (bus_rd) begin
                if (sel_ctrl) begin
                    rdata_q <= DATA_W'(run_q);
                end else if (sel_tlo) begin
                    rdata_q   <= time_i[DATA_W-1:0];
                    snap_hi_q <= time_i[NS_W-1:DATA_W];
                end else if (sel_thi) begin
                    rdata_q <= DATA_W'(snap_hi_q);
                end else if (sel_ilo) begin
                    rdata_q <= inc_q[DATA_W-1:0];
                end else if (sel_ihi) begin
                    rdata_q <= DATA_W'(inc_q[INC_W-1:DATA_W]);
                end else begin
                    rdata_q <= '0;
                end
            end
        end
    end

    assign run_o      = run_q;
    assign inc_o      = inc_q;
    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;

    // R10
    inc_stage_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel_ilo) |=> $stable(inc_o));

    // R2
    read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

    // R8
    time_stage_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel_tlo) |-> !load_o);

endmodule

// File: rtl/tod_timebase.sv
// Top of the nanosecond time counter: register interface, step generator
// and accumulator. Assumes a 32-bit register bus and a 64-bit time value.
module tod_timebase
    import tod_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 3,
    parameter int unsigned NS_W     = 64,
    parameter int unsigned FRAC_W   = 32,
    parameter int unsigned INC_W    = 40,
    parameter logic [INC_W-1:0] BASE_INC = 40'h01_9999_9999
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        link_rate,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic [NS_W-1:0]   time_ns
);

    localparam int unsigned STEP_W = INC_W + FACTOR_W;

    logic              run;
    logic              load;
    logic [NS_W-1:0]   load_val;
    logic [INC_W-1:0]  inc;
    logic [STEP_W-1:0] step;

    tod_regif #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .NS_W     (NS_W),
        .INC_W    (INC_W),
        .BASE_INC (BASE_INC)
    ) i_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .time_i     (time_ns),
        .run_o      (run),
        .load_o     (load),
        .load_val_o (load_val),
        .inc_o      (inc)
    );

    tod_step_gen #(
        .INC_W  (INC_W),
        .STEP_W (STEP_W)
    ) i_step (
        .inc_i       (inc),
        .link_rate_i (link_rate),
        .step_o      (step)
    );

    tod_accum #(
        .NS_W   (NS_W),
        .FRAC_W (FRAC_W),
        .STEP_W (STEP_W)
    ) i_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .load_i     (load),
        .load_val_i (load_val),
        .step_i     (step),
        .ns_o       (time_ns)
    );

    // R5
    slow_link_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_rate == LINK_SLOW && !load) |=> $stable(time_ns));

endmodule

// File: tb/test_tod_timebase.sv
module test_tod_timebase;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  link_rate = 2'd0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [63:0] time_ns;

    localparam logic [127:0] BASE = 128'h01_9999_9999;

    int unsigned checks = 0;
    int unsigned errors = 0;
    int unsigned cyc = 0;
    bit          done = 1'b0;

    // Reference of the last load: value, edge index and step per tick
    logic [63:0]  ref_v = '0;
    int unsigned  ref_l = 0;
    logic [127:0] ref_step = BASE;

    typedef struct {
        logic [31:0] data;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    tod_timebase i_tod_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_rate  (link_rate),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .time_ns    (time_ns)
    );

    // Expected time after the current edge count
    function automatic logic [63:0] now_ns();
        logic [127:0] p;
        p = 128'(cyc - ref_l) * ref_step;
        return ref_v + p[95:32];
    endfunction

    task automatic check64(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // Monitor: pop and compare each returned read
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2 got %h exp no-read", bus_rdata);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (bus_rdata !== e.data) begin
                    errors++;
                    $display("FAIL %s got %h exp %h", e.tag, bus_rdata, e.data);
                end
            end
        end
    end

    // Driver tasks are called at a falling edge and return at the next one
    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, input logic [31:0] exp, input string tag);
        exp_t e;
        e.data = exp; e.tag = tag;
        exp_q.push_back(e);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic load_time(input logic [63:0] v, input logic [127:0] step);
        wr_reg(3'd1, v[31:0]);
        bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = v[63:32];
        ref_l = cyc + 1; ref_v = v; ref_step = step;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        #500000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog got hung exp finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] hi_snap;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check64("R1 time", time_ns, 64'd0);
        rd_reg(3'd0, 32'h0, "R1 ctrl");
        rd_reg(3'd3, 32'h9999_9999, "R1 inc_lo");
        rd_reg(3'd4, 32'h0000_0001, "R1 inc_hi");

        // R2 run bit readback
        wr_reg(3'd0, 32'h1);
        rd_reg(3'd0, 32'h1, "R2 ctrl");

        // R9 load while running: exact value, then zero-fraction counting
        load_time(64'h1000, BASE);
        check64("R9 load exact", time_ns, 64'h1000);
        idle(37);
        check64("R3 run x1", time_ns, now_ns());
        rd_reg(3'd1, 32'(now_ns()), "R7 lo read");

        // R8 staging leaves time running; high write loads both halves
        wr_reg(3'd1, 32'h0000_DEAD);
        check64("R8 stage only", time_ns, now_ns());
        bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 32'h7;
        ref_l = cyc + 1; ref_v = 64'h7_0000_DEAD; ref_step = BASE;
        @(negedge clk);
        bus_wr = 1'b0;
        check64("R8 commit", time_ns, 64'h7_0000_DEAD);
        idle(5);
        check64("R9 after reload", time_ns, now_ns());

        // R7 snapshot across a carry into the high half
        load_time(64'h5_FFFF_FFF0, BASE);
        idle(2);
        hi_snap = now_ns() >> 32;
        rd_reg(3'd1, 32'(now_ns()), "R7 lo snap");
        idle(30);
        check64("R7 counter carried", time_ns, now_ns());
        rd_reg(3'd2, hi_snap, "R7 hi snap");

        // R4 rate factors
        link_rate = 2'd1;
        load_time(64'd0, BASE * 2);
        idle(50);
        check64("R4 x2", time_ns, now_ns());
        link_rate = 2'd2;
        load_time(64'd0, BASE * 20);
        idle(50);
        check64("R4 x20", time_ns, now_ns());

        // R5 slow link stops the counter
        link_rate = 2'd3;
        load_time(64'd100, 128'd0);
        idle(20);
        check64("R5 stop", time_ns, 64'd100);

        // R6 run cleared holds time; load still works
        link_rate = 2'd0;
        wr_reg(3'd0, 32'h0);
        load_time(64'h55, 128'd0);
        idle(20);
        check64("R6 hold", time_ns, 64'h55);
        rd_reg(3'd0, 32'h0, "R2 ctrl off");
        wr_reg(3'd0, 32'h1);

        // R10 staged increment low does not change the rate
        wr_reg(3'd3, 32'h0);
        load_time(64'd0, BASE);
        idle(25);
        check64("R10 staged", time_ns, now_ns());
        rd_reg(3'd3, 32'h9999_9999, "R11 staged hidden");

        // R10 commit to 3 ns per tick
        wr_reg(3'd4, 32'h3);
        load_time(64'd0, 128'h3_0000_0000);
        idle(10);
        check64("R10 commit", time_ns, 64'd30);
        rd_reg(3'd4, 32'h3, "R11 inc_hi");
        rd_reg(3'd3, 32'h0, "R11 inc_lo");

        // R3 half-nanosecond steps carry out of the fraction
        wr_reg(3'd3, 32'h8000_0000);
        wr_reg(3'd4, 32'h0);
        load_time(64'd0, 128'h8000_0000);
        idle(7);
        check64("R3 fraction carry", time_ns, 64'd3);

        idle(4);
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R2 got %0d pending exp 0", exp_q.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule